// File: doc/BRIEF.md
# Batch-Forming Rank-Ordered Bank Request Scheduler

This block chooses which waiting memory request each bank serves next when several threads share a multi-bank memory controller. Each request is held in a 16-entry buffer with its thread, bank and row, and with its arrival order. When no request of the current group is left, the scheduler opens a new group. For every thread and bank pair it flags up to five of the oldest waiting requests. It also gives each thread a rank. A thread that has few flagged requests on its busiest bank ranks high, so a short job's requests across several banks finish close together.

A bank that is idle takes its best waiting request by four keys, applied in turn. A flagged request wins over an unflagged one. Then a request to the row the bank opened last wins over one to another row. Then the thread with the higher rank wins. Last, the older request wins. The grant is a one-cycle pulse that carries the thread and row. The bank then stays busy until its completion strobe, and in that cycle the request leaves the buffer. Requests that arrive while a group is open stay unflagged, so a steady stream from one thread cannot push the flagged work back.

Top module: `batch_rank_sched`

## Requirements
- R1: While reset is held and after it is released, `enq_ready` is 1 and no `gnt_valid` bit is set.
- R2: The buffer holds 16 requests. `enq_ready` is low exactly when 16 are held. An enqueue offered while it is low is dropped and changes nothing.
- R3: A bank has at most one granted request outstanding. A `bank_done` bit on a bank with nothing outstanding is ignored. On a valid `bank_done`, the request leaves the buffer at that clock edge.
- R4: A new group forms in a cycle where no flagged request remains and at least one ungranted request waits. That cycle grants nothing. Each thread and bank pair gets up to 5 of its oldest ungranted requests flagged.
- R5: A bank grants an unflagged request only if no ungranted flagged request for that bank remains.
- R6: Among requests that tie on the flag, a request whose row equals the row last granted on that bank goes first. After reset, a bank has no open row.
- R7: At group formation each thread gets a rank. The thread with the smaller largest per-bank flagged count ranks higher. A tie goes to the thread with the smaller total flagged count, then to the lower thread number. Where flag and row tie, the higher-ranked thread goes first.
- R8: When flag, row hit and rank all tie, the request that was enqueued earlier goes first.
- R9: A flagged request stays flagged until it completes. Requests that arrive while any flagged request remains are unflagged. A new group forms only once every flagged request has completed.
- R10: When a bank is idle and has a candidate in a non-forming cycle, `gnt_valid` for it is high in the next cycle only, with the chosen thread and row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Offer a new request |
| enq_thread | input | 2 | Thread number of the offered request |
| enq_bank | input | 2 | Target bank of the offered request |
| enq_row | input | 8 | Target row of the offered request |
| enq_ready | output | 1 | Buffer has a free entry |
| bank_done | input | 4 | Per-bank completion strobe for the outstanding request |
| gnt_valid | output | 4 | Per-bank one-cycle grant pulse |
| gnt_thread | output | 8 | Per-bank granted thread, 2 bits per bank, bank 0 lowest |
| gnt_row | output | 32 | Per-bank granted row, 8 bits per bank, bank 0 lowest |

## Verification
Completions are held back while the buffer is filled past 16 entries. This separates accepted offers from dropped ones and shows that a bank does not grant twice while it is busy. One request to a bank that never completes keeps a group open. Work loaded behind it then shows the group's flags and thread ranks, the one quiet cycle when a group forms, and the rule that late arrivals wait. Runs of one thread to one bank with alternating rows set the row-hit preference against age. Long random traffic over a few rows, with completions that sometimes strike idle banks, mixes all the keys at once.

// File: rtl/sched_pkg.sv
// Shared helpers for the batch scheduler: default sizes and the two
// ordering rules (per-bank request priority and thread ranking).
package sched_pkg;
    localparam int DEF_THREADS = 4;
    localparam int DEF_BANKS   = 4;
    localparam int DEF_DEPTH   = 16;
    localparam int DEF_ROW_W   = 8;
    localparam int DEF_CAP     = 5;

    // True when request a must be served before request b on one bank.
    function automatic logic pri_beats(logic m_a, logic h_a, int r_a,
                                       logic m_b, logic h_b, int r_b,
                                       logic a_older);
        if (m_a != m_b) return m_a;
        if (h_a != h_b) return h_a;
        if (r_a != r_b) return (r_a < r_b);
        return a_older;
    endfunction

    // True when thread a ranks above thread b at group formation.
    function automatic logic rank_beats(int max_a, int tot_a, int id_a,
                                        int max_b, int tot_b, int id_b);
        if (max_a != max_b) return (max_a < max_b);
        if (tot_a != tot_b) return (tot_a < tot_b);
        return (id_a < id_b);
    endfunction
endpackage

// File: rtl/sched_req_buffer.sv
// Request storage: per-entry fields, granted and flagged bits, and a
// pairwise arrival-order matrix (older[i][j] = entry i came before j).
// Assumes free_vec only names valid entries and a write lands in a slot
// that is invalid in the same cycle.
module sched_req_buffer #(
    parameter int DEPTH = 16,
    parameter int TW    = 2,
    parameter int BW    = 2,
    parameter int ROW_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [TW-1:0]                   wr_thread,
    input  logic [BW-1:0]                   wr_bank,
    input  logic [ROW_W-1:0]                wr_row,
    input  logic [DEPTH-1:0]                issue_vec,
    input  logic [DEPTH-1:0]                free_vec,
    input  logic                            mark_load,
    input  logic [DEPTH-1:0]                mark_vec,
    output logic [DEPTH-1:0]                ent_valid,
    output logic [DEPTH-1:0]                ent_issued,
    output logic [DEPTH-1:0]                ent_marked,
    output logic [DEPTH-1:0][TW-1:0]        ent_thread,
    output logic [DEPTH-1:0][BW-1:0]        ent_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]     ent_row,
    output logic [DEPTH-1:0][DEPTH-1:0]     ent_older,
    output logic                            full
);
    localparam int SW = $clog2(DEPTH);

    logic [SW-1:0] alloc_idx;

    assign full = &ent_valid;

    // Pick the lowest-numbered free slot for the next write.
    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_valid[i]) alloc_idx = SW'(i);
        end
    end

    // Update entry state: completion, grant, flag load and new writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid  <= '0;
            ent_issued <= '0;
            ent_marked <= '0;
            ent_thread <= '0;
            ent_bank   <= '0;
            ent_row    <= '0;
            ent_older  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (free_vec[i]) begin
                    ent_valid[i]  <= 1'b0;
                    ent_issued[i] <= 1'b0;
                    ent_marked[i] <= 1'b0;
                end else begin
                    if (issue_vec[i]) ent_issued[i] <= 1'b1;
                    if (mark_load && mark_vec[i]) ent_marked[i] <= 1'b1;
                end
            end
            if (wr_en && !full) begin
                ent_valid[alloc_idx]  <= 1'b1;
                ent_issued[alloc_idx] <= 1'b0;
                ent_marked[alloc_idx] <= 1'b0;
                ent_thread[alloc_idx] <= wr_thread;
                ent_bank[alloc_idx]   <= wr_bank;
                ent_row[alloc_idx]    <= wr_row;
                for (int j = 0; j < DEPTH; j++) begin
                    ent_older[alloc_idx][j] <= 1'b0;
                    ent_older[j][alloc_idx] <= (j != int'(alloc_idx)) && ent_valid[j];
                end
            end
        end
    end
endmodule

// File: rtl/sched_batch_former.sv
// Combinational group builder: flags up to CAP oldest ungranted requests
// per thread and bank, and derives the thread ranks from those flags.
// Rank 0 is the highest. Assumes thread and bank fields fit their counts.
module sched_batch_former import sched_pkg::*; #(
    parameter int DEPTH       = 16,
    parameter int NUM_THREADS = 4,
    parameter int NUM_BANKS   = 4,
    parameter int TW          = 2,
    parameter int BW          = 2,
    parameter int CAP         = 5
) (
    input  logic [DEPTH-1:0]                ent_valid,
    input  logic [DEPTH-1:0]                ent_issued,
    input  logic [DEPTH-1:0][TW-1:0]        ent_thread,
    input  logic [DEPTH-1:0][BW-1:0]        ent_bank,
    input  logic [DEPTH-1:0][DEPTH-1:0]     ent_older,
    output logic [DEPTH-1:0]                mark_vec,
    output logic [NUM_THREADS-1:0][TW-1:0]  rank_nxt
);
    logic [DEPTH-1:0] elig;
    int               max_c [NUM_THREADS];
    int               tot_c [NUM_THREADS];

    assign elig = ent_valid & ~ent_issued;

    // Flag an entry when fewer than CAP older peers share thread and bank.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && elig[j] && ent_older[j][i] &&
                    ent_thread[j] == ent_thread[i] && ent_bank[j] == ent_bank[i])
                    cnt++;
            end
            mark_vec[i] = elig[i] && (cnt < CAP);
        end
    end

    // Per-thread largest per-bank flagged count and total flagged count.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            max_c[t] = 0;
            tot_c[t] = 0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                int per;
                per = 0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (mark_vec[i] && int'(ent_thread[i]) == t && int'(ent_bank[i]) == b)
                        per++;
                end
                tot_c[t] = tot_c[t] + per;
                if (per > max_c[t]) max_c[t] = per;
            end
        end
    end

    // Rank of a thread is the number of threads that beat it.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            int pos;
            pos = 0;
            for (int u = 0; u < NUM_THREADS; u++) begin
                if (u != t && rank_beats(max_c[u], tot_c[u], u, max_c[t], tot_c[t], t))
                    pos++;
            end
            rank_nxt[t] = TW'(pos);
        end
    end
endmodule

// File: rtl/sched_bank_pick.sv
// One bank's chooser: among ungranted requests to BANK_ID, select the one
// that beats all others by flag, row hit, thread rank, then age.
// Produces nothing unless the bank is idle and picking is enabled.
module sched_bank_pick import sched_pkg::*; #(
    parameter int DEPTH       = 16,
    parameter int NUM_THREADS = 4,
    parameter int TW          = 2,
    parameter int BW          = 2,
    parameter int ROW_W       = 8,
    parameter int BANK_ID     = 0
) (
    input  logic [DEPTH-1:0]                ent_valid,
    input  logic [DEPTH-1:0]                ent_issued,
    input  logic [DEPTH-1:0]                ent_marked,
    input  logic [DEPTH-1:0][TW-1:0]        ent_thread,
    input  logic [DEPTH-1:0][BW-1:0]        ent_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]     ent_row,
    input  logic [DEPTH-1:0][DEPTH-1:0]     ent_older,
    input  logic [NUM_THREADS-1:0][TW-1:0]  rank_q,
    input  logic                            open_valid,
    input  logic [ROW_W-1:0]                open_row,
    input  logic                            enable,
    output logic [DEPTH-1:0]                win_vec,
    output logic                            sel_valid,
    output logic [$clog2(DEPTH)-1:0]        sel_idx
);
    localparam int SW = $clog2(DEPTH);

    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] win_raw;

    // Candidates for this bank and their row-hit status.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cand[i] = ent_valid[i] && !ent_issued[i] && (int'(ent_bank[i]) == BANK_ID);
            hit[i]  = open_valid && (ent_row[i] == open_row);
        end
    end

    // An entry wins when it beats every other candidate.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            win_raw[i] = cand[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && cand[j] &&
                    !pri_beats(ent_marked[i], hit[i], int'(rank_q[ent_thread[i]]),
                               ent_marked[j], hit[j], int'(rank_q[ent_thread[j]]),
                               ent_older[i][j]))
                    win_raw[i] = 1'b0;
            end
        end
    end

    assign win_vec   = enable ? win_raw : '0;
    assign sel_valid = |win_vec;

    // Encode the winning slot number.
    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (win_vec[i]) sel_idx = SW'(i);
        end
    end
endmodule

// File: rtl/batch_rank_sched.sv
// Top of the batch scheduler. Holds per-bank busy state, open row and
// outstanding slot, the stored thread ranks, and the registered grant
// outputs. Assumes one completion per granted request on its bank.
module batch_rank_sched import sched_pkg::*; #(
    parameter int NUM_THREADS = DEF_THREADS,
    parameter int NUM_BANKS   = DEF_BANKS,
    parameter int DEPTH       = DEF_DEPTH,
    parameter int ROW_W       = DEF_ROW_W,
    parameter int MARK_CAP    = DEF_CAP,
    localparam int TW         = $clog2(NUM_THREADS),
    localparam int BW         = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enq_valid,
    input  logic [TW-1:0]               enq_thread,
    input  logic [BW-1:0]               enq_bank,
    input  logic [ROW_W-1:0]            enq_row,
    output logic                        enq_ready,
    input  logic [NUM_BANKS-1:0]        bank_done,
    output logic [NUM_BANKS-1:0]        gnt_valid,
    output logic [NUM_BANKS*TW-1:0]     gnt_thread,
    output logic [NUM_BANKS*ROW_W-1:0]  gnt_row
);
    localparam int SW = $clog2(DEPTH);

    logic [DEPTH-1:0]                ent_valid, ent_issued, ent_marked;
    logic [DEPTH-1:0][TW-1:0]        ent_thread;
    logic [DEPTH-1:0][BW-1:0]        ent_bank;
    logic [DEPTH-1:0][ROW_W-1:0]     ent_row;
    logic [DEPTH-1:0][DEPTH-1:0]     ent_older;
    logic                            buf_full;
    logic [DEPTH-1:0]                mark_vec;
    logic [NUM_THREADS-1:0][TW-1:0]  rank_nxt, rank_q;
    logic                            form_now;
    logic [NUM_BANKS-1:0][DEPTH-1:0] win_vec;
    logic [NUM_BANKS-1:0]            sel_valid;
    logic [NUM_BANKS-1:0][SW-1:0]    sel_idx;
    logic [DEPTH-1:0]                issue_vec, free_vec;
    logic [NUM_BANKS-1:0]            busy_q, open_v_q;
    logic [NUM_BANKS-1:0][SW-1:0]    slot_q;
    logic [NUM_BANKS-1:0][ROW_W-1:0] open_row_q, gnt_row_q;
    logic [NUM_BANKS-1:0][TW-1:0]    gnt_thr_q;
    logic [NUM_BANKS-1:0]            gnt_v_q;

    assign enq_ready  = !buf_full;
    assign gnt_valid  = gnt_v_q;
    assign gnt_thread = gnt_thr_q;
    assign gnt_row    = gnt_row_q;

    // A group forms when no flagged request is left and work is waiting.
    assign form_now = !(|(ent_valid & ent_marked)) && (|(ent_valid & ~ent_issued));

    sched_req_buffer #(
        .DEPTH(DEPTH), .TW(TW), .BW(BW), .ROW_W(ROW_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(enq_valid), .wr_thread(enq_thread), .wr_bank(enq_bank), .wr_row(enq_row),
        .issue_vec(issue_vec), .free_vec(free_vec),
        .mark_load(form_now), .mark_vec(mark_vec),
        .ent_valid(ent_valid), .ent_issued(ent_issued), .ent_marked(ent_marked),
        .ent_thread(ent_thread), .ent_bank(ent_bank), .ent_row(ent_row),
        .ent_older(ent_older), .full(buf_full)
    );

    sched_batch_former #(
        .DEPTH(DEPTH), .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS),
        .TW(TW), .BW(BW), .CAP(MARK_CAP)
    ) u_form (
        .ent_valid(ent_valid), .ent_issued(ent_issued), .ent_thread(ent_thread),
        .ent_bank(ent_bank), .ent_older(ent_older),
        .mark_vec(mark_vec), .rank_nxt(rank_nxt)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sched_bank_pick #(
            .DEPTH(DEPTH), .NUM_THREADS(NUM_THREADS), .TW(TW), .BW(BW),
            .ROW_W(ROW_W), .BANK_ID(b)
        ) u_pick (
            .ent_valid(ent_valid), .ent_issued(ent_issued), .ent_marked(ent_marked),
            .ent_thread(ent_thread), .ent_bank(ent_bank), .ent_row(ent_row),
            .ent_older(ent_older), .rank_q(rank_q),
            .open_valid(open_v_q[b]), .open_row(open_row_q[b]),
            .enable(!busy_q[b] && !form_now),
            .win_vec(win_vec[b]), .sel_valid(sel_valid[b]), .sel_idx(sel_idx[b])
        );
    end

    // Gather entries granted this cycle and entries completing this cycle.
    always_comb begin
        issue_vec = '0;
        free_vec  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            issue_vec = issue_vec | win_vec[b];
            if (busy_q[b] && bank_done[b]) free_vec[slot_q[b]] = 1'b1;
        end
    end

    // Latch thread ranks at group formation.
    always_ff @(posedge clk) begin
        if (!rst_n) rank_q <= '0;
        else if (form_now) rank_q <= rank_nxt;
    end

    // Per-bank busy, open row, outstanding slot and grant outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= '0;
            open_v_q   <= '0;
            slot_q     <= '0;
            open_row_q <= '0;
            gnt_v_q    <= '0;
            gnt_thr_q  <= '0;
            gnt_row_q  <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                gnt_v_q[b] <= sel_valid[b];
                if (sel_valid[b]) begin
                    busy_q[b]     <= 1'b1;
                    slot_q[b]     <= sel_idx[b];
                    open_v_q[b]   <= 1'b1;
                    open_row_q[b] <= ent_row[sel_idx[b]];
                    gnt_thr_q[b]  <= ent_thread[sel_idx[b]];
                    gnt_row_q[b]  <= ent_row[sel_idx[b]];
                end else if (busy_q[b] && bank_done[b]) begin
                    busy_q[b] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/batch_rank_sched_chk.sv
// Checker for the batch scheduler, bound into every instance of the top.
// Tracks buffer occupancy and outstanding grants from the ports and
// compares them with the block's behaviour.
module batch_rank_sched_chk #(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 16,
    parameter int BW        = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      enq_valid,
    input logic                      enq_ready,
    input logic [NUM_BANKS-1:0]      bank_done,
    input logic [NUM_BANKS-1:0]      gnt_valid,
    input logic                      form_now,
    input logic [DEPTH-1:0]          issue_vec,
    input logic [DEPTH-1:0]          ent_valid,
    input logic [DEPTH-1:0]          ent_issued,
    input logic [DEPTH-1:0]          ent_marked,
    input logic [DEPTH-1:0][BW-1:0]  ent_bank
);
    int                   occ;
    logic [NUM_BANKS-1:0] pend;
    int                   mcount;

    assign mcount = $countones(ent_valid & ent_marked);

    // Occupancy and outstanding-grant bookkeeping from port activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ  <= 0;
            pend <= '0;
        end else begin
            int nocc;
            nocc = occ + ((enq_valid && enq_ready) ? 1 : 0);
            for (int b = 0; b < NUM_BANKS; b++) begin
                if ((pend[b] || gnt_valid[b]) && bank_done[b]) nocc--;
            end
            occ  <= nocc;
            pend <= (pend | gnt_valid) & ~bank_done;
        end
    end

    // Immediate checks on occupancy, outstanding grants and flag priority.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            p_ready_tracks_room_r2: assert (enq_ready == (occ < DEPTH))
                else $error("enq_ready disagrees with occupancy %0d", occ);
            for (int b = 0; b < NUM_BANKS; b++) begin
                p_one_outstanding_r3: assert (!(gnt_valid[b] && pend[b]))
                    else $error("bank %0d granted while outstanding", b);
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (issue_vec[i] && !ent_marked[i]) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        p_flagged_first_r5: assert (!(ent_valid[j] && !ent_issued[j] &&
                                                      ent_marked[j] && ent_bank[j] == ent_bank[i]))
                            else $error("unflagged entry %0d passed flagged entry %0d", i, j);
                    end
                end
            end
        end
    end

    p_quiet_formation_r4: assert property (@(posedge clk) disable iff (!rst_n)
        form_now |=> (gnt_valid == '0));

    p_flags_grow_only_at_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mcount > $past(mcount)) |-> $past(form_now));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pulse
        p_grant_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[b] |=> !gnt_valid[b]);
    end
endmodule

bind batch_rank_sched batch_rank_sched_chk #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .BW(BW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .bank_done(bank_done), .gnt_valid(gnt_valid), .form_now(form_now),
    .issue_vec(issue_vec), .ent_valid(ent_valid), .ent_issued(ent_issued),
    .ent_marked(ent_marked), .ent_bank(ent_bank)
);

// File: tb/tb_batch_rank_sched.sv
module tb_batch_rank_sched;
    localparam int NT = 4, NB = 4, D = 16, CAP = 5, RW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enq_valid = 1'b0;
    logic [1:0]      enq_thread = '0;
    logic [1:0]      enq_bank = '0;
    logic [RW-1:0]   enq_row = '0;
    logic            enq_ready;
    logic [NB-1:0]   bank_done = '0;
    logic [NB-1:0]   gnt_valid;
    logic [NB*2-1:0] gnt_thread;
    logic [NB*RW-1:0] gnt_row;

    always #2.5 clk = ~clk;

    batch_rank_sched dut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_thread(enq_thread),
        .enq_bank(enq_bank), .enq_row(enq_row), .enq_ready(enq_ready),
        .bank_done(bank_done), .gnt_valid(gnt_valid), .gnt_thread(gnt_thread),
        .gnt_row(gnt_row)
    );

    int    checks = 0, fails = 0;
    string tag = "R1";
    bit    checking = 0;
    bit    finished = 0;
    logic [NB-1:0] done_mask = '0;

    // Behavioural reference: entries with arrival sequence numbers.
    int m_v[D], m_t[D], m_b[D], m_r[D], m_seq[D], m_mk[D], m_is[D];
    int m_busy[NB], m_slot[NB], m_ov[NB], m_or[NB], m_gv[NB], m_gt[NB], m_gr[NB];
    int m_rank[NT];
    int seqc;

    function automatic bit better(int i, int j, int b);
        int hi, hj;
        hi = (m_ov[b] != 0 && m_r[i] == m_or[b]) ? 1 : 0;
        hj = (m_ov[b] != 0 && m_r[j] == m_or[b]) ? 1 : 0;
        if (m_mk[i] != m_mk[j]) return m_mk[i] > m_mk[j];
        if (hi != hj) return hi > hj;
        if (m_rank[m_t[i]] != m_rank[m_t[j]]) return m_rank[m_t[i]] < m_rank[m_t[j]];
        return m_seq[i] < m_seq[j];
    endfunction

    function automatic int occupancy();
        int n;
        n = 0;
        for (int i = 0; i < D; i++) n += m_v[i];
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) begin
                m_v[i] = 0; m_mk[i] = 0; m_is[i] = 0;
            end
            for (int b = 0; b < NB; b++) begin
                m_busy[b] = 0; m_ov[b] = 0; m_gv[b] = 0;
            end
            for (int t = 0; t < NT; t++) m_rank[t] = 0;
            seqc = 0;
        end else begin
            int anym, pend, nval, fslot, form;
            anym = 0; pend = 0; fslot = -1;
            nval = occupancy();
            for (int i = D - 1; i >= 0; i--) begin
                if (m_v[i] != 0) begin
                    if (m_mk[i] != 0) anym = 1;
                    if (m_is[i] == 0) pend = 1;
                end else fslot = i;
            end
            form = (anym == 0 && pend != 0) ? 1 : 0;
            for (int b = 0; b < NB; b++) begin
                int best;
                best = -1;
                m_gv[b] = 0;
                if (form == 0 && m_busy[b] == 0) begin
                    for (int i = 0; i < D; i++) begin
                        if (m_v[i] != 0 && m_is[i] == 0 && m_b[i] == b)
                            if (best < 0 || better(i, best, b)) best = i;
                    end
                end
                if (best >= 0) begin
                    m_gv[b] = 1; m_gt[b] = m_t[best]; m_gr[b] = m_r[best];
                    m_is[best] = 1; m_busy[b] = 1; m_slot[b] = best;
                    m_ov[b] = 1; m_or[b] = m_r[best];
                end else if (m_busy[b] != 0 && bank_done[b]) begin
                    m_busy[b] = 0;
                    m_v[m_slot[b]] = 0; m_mk[m_slot[b]] = 0; m_is[m_slot[b]] = 0;
                end
            end
            if (form != 0) begin
                int per[NT][NB];
                int mx[NT], tot[NT];
                for (int t = 0; t < NT; t++) begin
                    mx[t] = 0; tot[t] = 0;
                    for (int b = 0; b < NB; b++) per[t][b] = 0;
                end
                for (int i = 0; i < D; i++) begin
                    if (m_v[i] != 0 && m_is[i] == 0) begin
                        int c;
                        c = 0;
                        for (int j = 0; j < D; j++)
                            if (m_v[j] != 0 && m_is[j] == 0 && m_t[j] == m_t[i] &&
                                m_b[j] == m_b[i] && m_seq[j] < m_seq[i]) c++;
                        if (c < CAP) begin
                            m_mk[i] = 1;
                            per[m_t[i]][m_b[i]]++;
                        end
                    end
                end
                for (int t = 0; t < NT; t++)
                    for (int b = 0; b < NB; b++) begin
                        tot[t] += per[t][b];
                        if (per[t][b] > mx[t]) mx[t] = per[t][b];
                    end
                for (int t = 0; t < NT; t++) begin
                    m_rank[t] = 0;
                    for (int u = 0; u < NT; u++) begin
                        if (u != t && (mx[u] < mx[t] || (mx[u] == mx[t] &&
                            (tot[u] < tot[t] || (tot[u] == tot[t] && u < t)))))
                            m_rank[t]++;
                    end
                end
            end
            if (enq_valid && nval < D) begin
                m_v[fslot] = 1; m_t[fslot] = enq_thread; m_b[fslot] = enq_bank;
                m_r[fslot] = enq_row; m_seq[fslot] = seqc; m_mk[fslot] = 0; m_is[fslot] = 0;
                seqc++;
            end
        end
    end

    // Compare every output with the reference away from the active edge.
    always @(negedge clk) begin
        if (checking && !finished) begin
            bit exp_rdy;
            exp_rdy = occupancy() < D;
            checks++;
            if (enq_ready !== exp_rdy) begin
                fails++;
                $display("FAIL %s enq_ready: got %0b expected %0b", tag, enq_ready, exp_rdy);
            end
            for (int b = 0; b < NB; b++) begin
                checks++;
                if (gnt_valid[b] !== (m_gv[b] != 0) ||
                    (m_gv[b] != 0 && (int'(gnt_thread[b*2 +: 2]) != m_gt[b] ||
                                      int'(gnt_row[b*RW +: RW]) != m_gr[b]))) begin
                    fails++;
                    $display("FAIL %s bank %0d: got v=%0b t=%0d r=%0d expected v=%0d t=%0d r=%0d",
                             tag, b, gnt_valid[b], gnt_thread[b*2 +: 2], gnt_row[b*RW +: RW],
                             m_gv[b], m_gt[b], m_gr[b]);
                end
            end
        end
    end

    // Random completion strobes on the enabled banks, idle or not.
    always @(negedge clk) begin
        for (int b = 0; b < NB; b++)
            bank_done[b] <= done_mask[b] && ($urandom_range(0, 2) == 0);
    end

    task automatic push(int t, int b, int r);
        enq_valid = 1'b1; enq_thread = 2'(t); enq_bank = 2'(b); enq_row = RW'(r);
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        done_mask = '1;
        for (int k = 0; k < 2000 && occupancy() != 0; k++) @(negedge clk);
        idle(4);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        idle(3);
        checking = 1;
        // R1: state while reset is held
        checks++;
        if (enq_ready !== 1'b1 || gnt_valid !== '0) begin
            fails++;
            $display("FAIL R1 reset: got ready=%0b gnt=%b expected ready=1 gnt=0000",
                     enq_ready, gnt_valid);
        end
        rst_n = 1'b1;
        idle(2);

        // R2: fill past capacity with completions held off; R3: one grant per bank
        tag = "R2";
        for (int i = 0; i < 18; i++) push(i % NT, (i / 3) % NB, i);
        idle(3);
        tag = "R3";
        drain();

        // R4: more than five from one thread to one bank behind an open group
        tag = "R4";
        done_mask = '0;
        push(0, 3, 9);
        for (int i = 0; i < 7; i++) push(1, 2, 20 + i);
        push(2, 2, 40);
        idle(2);
        drain();

        // R6: alternating rows on one bank, row hits pass older misses
        tag = "R6";
        done_mask = '0;
        push(0, 3, 9);
        for (int i = 0; i < 6; i++) push(0, 0, (i % 2 == 0) ? 1 : 2);
        drain();

        // R7: threads with different per-bank loads compete inside a group
        tag = "R7";
        done_mask = '0;
        push(0, 3, 9);
        for (int i = 0; i < 3; i++) push(3, 1, 50 + i);
        push(1, 1, 60); push(1, 2, 61);
        push(2, 1, 70);
        push(0, 1, 80); push(0, 0, 81);
        drain();

        // R5 and R9: late arrivals wait behind a still-open group
        tag = "R5";
        done_mask = '0;
        push(0, 3, 9);
        push(1, 0, 5); push(2, 0, 6); push(1, 0, 7);
        done_mask = 4'b0001;
        tag = "R9";
        for (int i = 0; i < 6; i++) push(3, 0, 5);
        idle(40);
        drain();

        // R8: equal keys, arrival order decides
        tag = "R8";
        done_mask = '0;
        push(2, 3, 9);
        for (int i = 0; i < 5; i++) push(2, 1, 100 + i);
        drain();

        // R10: long random traffic over few rows
        tag = "R10";
        done_mask = '1;
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 1) == 1)
                push($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
            else
                @(negedge clk);
        end
        drain();

        finished = 1;
        summary();
    end
endmodule